// File: doc/BRIEF.md
# Two-Channel PWM Register File and Pad Control

This block is the software-visible front of a two-channel pulse-width peripheral. It decodes a plain 32-bit word-addressed read/write bus and stores the settings for each channel: a 16-bit frequency control word held as two byte registers, an 8-bit on-time and an 8-bit period. Two shared registers hold one 4-bit control field per channel and one output-select bit per channel. It sends these values to the external variable-frequency and constant-frequency generators.

The block takes back each generator's waveform. For each channel it picks one waveform and applies a force-high override. It then drives the pad as either push-pull or open-drain, or releases the pad entirely through an active-low output enable. Software enables a channel by clearing its output-enable-bar bit and setting its start and open-drain bits. It disables the channel by doing the reverse.

Top module: `pwm_ctl_top`

## Requirements
- R1: After reset every register reads zero except the shared control register, which reads 0x22 (the output-enable-bar bit of every channel set). All pads are released (pad_oe_o = 0), run_o = 0 and cword_o = 0.
- R2: The shared control register is at byte offset 0x00. Channel c owns bits 4c+3..4c. Within a field, bit 0 is start (driven on run_o[c]), bit 1 is active-low output enable, bit 2 is force-high and bit 3 is open-drain. All 8 bits read back as written.
- R3: The output-select register is at 0x04. Only bit 4c is stored: 1 selects the constant-frequency waveform for channel c and 0 selects the variable-frequency waveform. All other bits read zero.
- R4: The upper byte of channel c's control word is at 0x08+8c and the lower byte is at 0x0C+8c. Each register keeps bits 7..0. cword_o[16c+15:16c] shows {upper, lower}.
- R5: The on-time of channel c is at 0x18+8c and its period is at 0x1C+8c, each 8 bits wide, shown on on_time_o and period_o at [8c+7:8c].
- R6: Offsets not listed here, and any address whose two low bits are not zero, read as zero, and writes to them change no register.
- R7: With force-high set, the channel's output level is 1 whatever the generator inputs are.
- R8: With force-high clear, the output level is const_wave_i[c] when the select bit is 1 and var_wave_i[c] when it is 0.
- R9: In open-drain mode with the output enabled, the pad drives 0 (pad_out_o = 0, pad_oe_o = 1) when the level is 0, and the pad is released (pad_oe_o = 0) when the level is 1.
- R10: In push-pull mode with the output enabled, pad_oe_o = 1 and pad_out_o equals the level.
- R11: With output-enable-bar set, pad_oe_o = 0 for that channel in every other mode.
- R12: A read asserted in one cycle presents its data on bus_rdata the next cycle. bus_rdata holds that value until the next read, even if the register is written in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| var_wave_i | input | NCH | Variable-frequency generator waveforms |
| const_wave_i | input | NCH | Constant-frequency generator waveforms |
| run_o | output | NCH | Per-channel start bits to the generators |
| cword_o | output | 16*NCH | Per-channel frequency control words |
| on_time_o | output | 8*NCH | Per-channel on-time |
| period_o | output | 8*NCH | Per-channel period |
| pad_out_o | output | NCH | Pad data level |
| pad_oe_o | output | NCH | Pad drive enable (1 = driven) |

## Verification
A register that stores the wrong value, or a decode that lands on the wrong slot, shows on the generator-side outputs one cycle after the write. A read of that slot shows it one cycle after the read strobe. A decode that ignores the low address bits, or that aliases unmapped words, corrupts a neighbouring register, which a later read-back exposes. The pad stage is combinational from the stored control field and the generator inputs. A wrong override or drive mode therefore shows on pad_out_o and pad_oe_o in the same cycle as the input change.

// File: rtl/pwm_ctl_pkg.sv
package pwm_ctl_pkg;
    // Bit positions inside one channel's control field
    localparam int FLD_W      = 4;
    localparam int FLD_RUN    = 0;
    localparam int FLD_OEB    = 1;
    localparam int FLD_FORCE  = 2;
    localparam int FLD_OD     = 3;
    // Word indices (byte offset / 4)
    localparam int W_CTRL     = 0;
    localparam int W_SEL      = 1;
    localparam int W_CW_BASE  = 2;   // upper byte; lower at +1; stride 2 per channel
    localparam int BYTE_W     = 8;
    localparam int DATA_W     = 32;
endpackage

// File: rtl/pwm_reg_bank.sv
module pwm_reg_bank
    import pwm_ctl_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata_o,
    output logic [FLD_W*NCH-1:0]    ctrl_o,
    output logic [NCH-1:0]          sel_o,
    output logic [2*BYTE_W*NCH-1:0] cword_o,
    output logic [BYTE_W*NCH-1:0]   on_o,
    output logic [BYTE_W*NCH-1:0]   per_o
);
    localparam int CW_W   = FLD_W * NCH;
    localparam int WI_W   = AW - 2;
    localparam int W_ON_B = W_CW_BASE + 2 * NCH;  // on-time; period at +1

    typedef struct packed {
        logic [CW_W-1:0]                 ctrl;
        logic [NCH-1:0]                  sel;
        logic [NCH-1:0][BYTE_W-1:0]      cw_hi;
        logic [NCH-1:0][BYTE_W-1:0]      cw_lo;
        logic [NCH-1:0][BYTE_W-1:0]      on_t;
        logic [NCH-1:0][BYTE_W-1:0]      per;
        logic [DATA_W-1:0]               rdata;
    } bank_t;

    function automatic logic [CW_W-1:0] ctrl_reset();
        logic [CW_W-1:0] v;
        v = '0;
        for (int c = 0; c < NCH; c++) v[FLD_W*c + FLD_OEB] = 1'b1;
        return v;
    endfunction

    bank_t st_d, st_q;
    logic [WI_W-1:0] word;
    logic            aligned;
    logic [DATA_W-1:0] rd_val;

    assign word    = addr[AW-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        st_d   = st_q;
        rd_val = '0;
        if (aligned) begin
            if (word == WI_W'(W_CTRL)) rd_val[CW_W-1:0] = st_q.ctrl;
            if (word == WI_W'(W_SEL))
                for (int c = 0; c < NCH; c++) rd_val[FLD_W*c] = st_q.sel[c];
            for (int c = 0; c < NCH; c++) begin
                if (word == WI_W'(W_CW_BASE + 2*c))     rd_val[BYTE_W-1:0] = st_q.cw_hi[c];
                if (word == WI_W'(W_CW_BASE + 2*c + 1)) rd_val[BYTE_W-1:0] = st_q.cw_lo[c];
                if (word == WI_W'(W_ON_B + 2*c))        rd_val[BYTE_W-1:0] = st_q.on_t[c];
                if (word == WI_W'(W_ON_B + 2*c + 1))    rd_val[BYTE_W-1:0] = st_q.per[c];
            end
        end
        if (wr_en && aligned) begin
            if (word == WI_W'(W_CTRL)) st_d.ctrl = wdata[CW_W-1:0];
            if (word == WI_W'(W_SEL))
                for (int c = 0; c < NCH; c++) st_d.sel[c] = wdata[FLD_W*c];
            for (int c = 0; c < NCH; c++) begin
                if (word == WI_W'(W_CW_BASE + 2*c))     st_d.cw_hi[c] = wdata[BYTE_W-1:0];
                if (word == WI_W'(W_CW_BASE + 2*c + 1)) st_d.cw_lo[c] = wdata[BYTE_W-1:0];
                if (word == WI_W'(W_ON_B + 2*c))        st_d.on_t[c]  = wdata[BYTE_W-1:0];
                if (word == WI_W'(W_ON_B + 2*c + 1))    st_d.per[c]   = wdata[BYTE_W-1:0];
            end
        end
        if (rd_en) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ctrl <= ctrl_reset();
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            cword_o[2*BYTE_W*c +: 2*BYTE_W] = {st_q.cw_hi[c], st_q.cw_lo[c]};
            on_o[BYTE_W*c +: BYTE_W]        = st_q.on_t[c];
            per_o[BYTE_W*c +: BYTE_W]       = st_q.per[c];
        end
    end
    assign ctrl_o  = st_q.ctrl;
    assign sel_o   = st_q.sel;
    assign rdata_o = st_q.rdata;

    // R2
    ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(0)) |=> (ctrl_o == $past(wdata[CW_W-1:0])));
    // R6
    misaligned_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[1:0] != 2'b00) |=>
            $stable({st_q.ctrl, st_q.sel, st_q.cw_hi, st_q.cw_lo, st_q.on_t, st_q.per}));
    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata_o));
endmodule

// File: rtl/pwm_pad_lane.sv
module pwm_pad_lane
    import pwm_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLD_W-1:0] fld,
    input  logic             sel_const,
    input  logic             var_wave,
    input  logic             const_wave,
    output logic             pad_out,
    output logic             pad_oe
);
    logic level;
    logic oeb, force_hi, od;

    assign oeb      = fld[FLD_OEB];
    assign force_hi = fld[FLD_FORCE];
    assign od       = fld[FLD_OD];

    always_comb begin
        level = force_hi ? 1'b1 : (sel_const ? const_wave : var_wave);
        if (oeb) begin
            pad_out = 1'b0;
            pad_oe  = 1'b0;
        end else if (od) begin
            pad_out = 1'b0;
            pad_oe  = ~level;
        end else begin
            pad_out = level;
            pad_oe  = 1'b1;
        end
    end

    // R11
    oeb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oeb |-> !pad_oe);
    // R9
    od_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (od && !oeb) |-> (!pad_out && (pad_oe != force_hi || !pad_oe)));
    // R7
    force_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_hi && !oeb && !od) |-> (pad_out && pad_oe));
    // R10
    pp_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oeb && !od) |-> pad_oe);
endmodule

// File: rtl/pwm_ctl_top.sv
module pwm_ctl_top
    import pwm_ctl_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [NCH-1:0]          var_wave_i,
    input  logic [NCH-1:0]          const_wave_i,
    output logic [NCH-1:0]          run_o,
    output logic [2*BYTE_W*NCH-1:0] cword_o,
    output logic [BYTE_W*NCH-1:0]   on_time_o,
    output logic [BYTE_W*NCH-1:0]   period_o,
    output logic [NCH-1:0]          pad_out_o,
    output logic [NCH-1:0]          pad_oe_o
);
    localparam int CW_W = FLD_W * NCH;

    logic [CW_W-1:0] ctrl;
    logic [NCH-1:0]  sel;

    pwm_reg_bank #(.NCH(NCH), .AW(AW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr_en   (bus_wr),
        .rd_en   (bus_rd),
        .wdata   (bus_wdata),
        .rdata_o (bus_rdata),
        .ctrl_o  (ctrl),
        .sel_o   (sel),
        .cword_o (cword_o),
        .on_o    (on_time_o),
        .per_o   (period_o)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        assign run_o[c] = ctrl[FLD_W*c + FLD_RUN];
        pwm_pad_lane u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .fld        (ctrl[FLD_W*c +: FLD_W]),
            .sel_const  (sel[c]),
            .var_wave   (var_wave_i[c]),
            .const_wave (const_wave_i[c]),
            .pad_out    (pad_out_o[c]),
            .pad_oe     (pad_oe_o[c])
        );
    end
endmodule

// File: tb/pwm_ctl_top_tb.sv
module pwm_ctl_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  var_w = '0, const_w = '0;
    logic [1:0]  run, pad_out, pad_oe;
    logic [31:0] cword;
    logic [15:0] on_t, per;
    int n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    pwm_ctl_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .var_wave_i(var_w), .const_wave_i(const_w), .run_o(run),
        .cword_o(cword), .on_time_o(on_t), .period_o(per),
        .pad_out_o(pad_out), .pad_oe_o(pad_oe)
    );

    typedef struct packed {
        logic [7:0]  a;
        logic [31:0] w;
        logic [31:0] e;
    } vec_t;

    localparam vec_t VECS [15] = '{
        '{8'h00, 32'hFFFF_FFFF, 32'h0000_00FF},  // R2
        '{8'h00, 32'h0000_005A, 32'h0000_005A},  // R2
        '{8'h02, 32'hFFFF_FFFF, 32'h0000_0000},  // R6 misaligned
        '{8'h04, 32'hFFFF_FFFF, 32'h0000_0011},  // R3
        '{8'h08, 32'h0000_1234, 32'h0000_0034},  // R4
        '{8'h0C, 32'h0000_ABCD, 32'h0000_00CD},  // R4
        '{8'h10, 32'h0000_0077, 32'h0000_0077},  // R4
        '{8'h14, 32'h0000_0188, 32'h0000_0088},  // R4
        '{8'h18, 32'h0000_00C3, 32'h0000_00C3},  // R5
        '{8'h1C, 32'h0000_003C, 32'h0000_003C},  // R5
        '{8'h20, 32'h0000_0099, 32'h0000_0099},  // R5
        '{8'h24, 32'h0000_01FF, 32'h0000_00FF},  // R5
        '{8'h28, 32'hFFFF_FFFF, 32'h0000_0000},  // R6 unmapped
        '{8'hFC, 32'hFFFF_FFFF, 32'h0000_0000},  // R6 unmapped
        '{8'h07, 32'hFFFF_FFFF, 32'h0000_0000}   // R6 misaligned
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pads(logic [1:0] vw, logic [1:0] cw, logic [1:0] eo,
                        logic [1:0] ee, string req);
        @(negedge clk);
        var_w = vw; const_w = cw;
        #1;
        check({req, " pad_out"}, {30'd0, pad_out}, {30'd0, eo});
        check({req, " pad_oe"},  {30'd0, pad_oe},  {30'd0, ee});
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        report();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        #1;
        check("R1 pad_oe", {30'd0, pad_oe}, 32'd0);
        check("R1 run", {30'd0, run}, 32'd0);
        check("R1 cword", cword, 32'd0);
        rst_n = 1'b1;
        rd(8'h00, d); check("R1 ctrl", d, 32'h22);
        rd(8'h04, d); check("R1 sel", d, 32'h0);
        rd(8'h08, d); check("R1 cw", d, 32'h0);
        rd(8'h24, d); check("R1 per", d, 32'h0);

        // Table walk: write then read back
        for (int i = 0; i < 15; i++) begin
            wr(VECS[i].a, VECS[i].w);
            rd(VECS[i].a, d);
            check($sformatf("R2-6 table %0d", i), d, VECS[i].e);
        end

        // R6: ignored writes left neighbours intact
        rd(8'h00, d); check("R6 ctrl intact", d, 32'h5A);
        rd(8'h04, d); check("R6 sel intact", d, 32'h11);
        // R4 / R5 generator-side values
        check("R4 cword_o", cword, 32'h7788_34CD);
        check("R5 on_time_o", {16'd0, on_t}, 32'h99C3);
        check("R5 period_o", {16'd0, per}, 32'hFF3C);
        // R2 start bits: ctrl=0x5A -> ch0 start 0, ch1 start 1
        check("R2 run_o", {30'd0, run}, 32'd2);

        // R12 read data holds across a write
        wr(8'h18, 32'h55);
        check("R12 rdata hold", bus_rdata, 32'h11);
        rd(8'h18, d); check("R12 new read", d, 32'h55);

        // Pad stage
        wr(8'h00, 32'h00);   // both enabled, push-pull
        wr(8'h04, 32'h01);   // ch0 const, ch1 var
        pads(2'b11, 2'b00, 2'b10, 2'b11, "R8 R10 a");
        pads(2'b00, 2'b11, 2'b01, 2'b11, "R8 R10 b");
        wr(8'h00, 32'h88);   // open-drain both
        pads(2'b00, 2'b11, 2'b00, 2'b10, "R9 a");
        pads(2'b11, 2'b00, 2'b00, 2'b01, "R9 b");
        wr(8'h00, 32'h44);   // force-high push-pull
        pads(2'b00, 2'b00, 2'b11, 2'b11, "R7 pp");
        wr(8'h00, 32'hCC);   // force-high open-drain
        pads(2'b00, 2'b00, 2'b00, 2'b00, "R7 od");
        wr(8'h00, 32'hAA);   // oeb + open-drain
        pads(2'b00, 2'b00, 2'b00, 2'b00, "R11 od");
        wr(8'h00, 32'h66);   // oeb + force push-pull
        pads(2'b11, 2'b11, 2'b00, 2'b00, "R11 pp");
        wr(8'h00, 32'h28);   // ch0 od enabled, ch1 released
        pads(2'b00, 2'b00, 2'b00, 2'b01, "R11 mixed");

        report();
    end
endmodule